// File: doc/BRIEF.md
# External Bus Access Sequencer with Wait-State Extension

This block runs one external memory access at a time. An internal requester offers an address, a read/write flag and write data over a valid/ready handshake. The block then steps the external bus through three phases: address, command and recovery. Every phase change happens on a clock edge. The block drives the external address, an active-low chip select and active-low read and write strobes. On a read it captures the 32-bit external data bus at the edge that ends the command phase. At the end of recovery it pulses a completion signal, and read data is valid on that cycle.

The length of each phase is set by configuration inputs, with one command length for reads and another for writes. These values are latched when a request is accepted. An active-low WAIT input from the device can stretch the command phase. In synchronous mode, WAIT must meet setup and hold times to the clock and acts one edge after it is sampled. In asynchronous mode, WAIT may change at any time. It passes through a synchronizer chain, so it acts two edges after it is sampled. For that reason the command length is forced up to the depth of the chain, and a sticky configuration-error flag is set. A separate enable bit switches WAIT handling off entirely.

Top module: `xbus_access_seq`

## Requirements
- R1: `req_ready_o` is 1 exactly when no access is in progress. A request is accepted on the rising edge where `req_valid_i` and `req_ready_o` are both 1. Each access runs the address phase, then the command phase, then the recovery phase, and then returns to idle.
- R2: The address phase lasts `cfg_addr_len_i` cycles, and a value of 0 counts as 1. During it `bus_cs_no` is 0, both strobes are 1, and `bus_addr_o` carries the accepted address. The chip select stays 0 through the command phase.
- R3: In the command phase, `bus_rd_no` is 0 for a read (`req_we_i`=0) and `bus_wr_no` is 0 for a write (`req_we_i`=1), together with `bus_wdata_o` equal to the accepted data. The two strobes are never 0 together. The minimum length is `cfg_rd_cmd_len_i` for reads and `cfg_wr_cmd_len_i` for writes, and 0 counts as 1. With `cfg_wait_en_i`=0 the phase lasts exactly this minimum, whatever WAIT does.
- R4: In synchronous mode (`cfg_async_i`=0), `bus_wait_ni` is sampled at every edge from the edge that ends the address phase onward. The command phase ends at the first edge where the minimum is used up and the sample from the previous edge was 1. With W consecutive low samples starting at the address-ending edge, the phase lasts max(N, W+1) cycles.
- R5: In asynchronous mode (`cfg_async_i`=1), the command phase ends at the first edge where the minimum is used up and the sample taken two edges earlier was 1. With W>0 low samples it lasts max(N, W+2) cycles. With W=0 it lasts N cycles.
- R6: If asynchronous mode is accepted with a selected command length below 2, the command phase uses 2, and `cfg_err_o` goes to 1. The flag stays at 1 until reset.
- R7: For a read, `bus_data_i` is captured at the edge that ends the command phase and is presented on `rdata_o` while `done_o` is 1.
- R8: The recovery phase lasts `cfg_rec_len_i` cycles, and 0 counts as 1. During it the chip select and both strobes are 1. `done_o` is 1 for exactly the one cycle after recovery ends.
- R9: During and right after reset, `req_ready_o`=1, `bus_cs_no`=`bus_rd_no`=`bus_wr_no`=1, `done_o`=0 and `cfg_err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_async_i | input | 1 | 1: WAIT is asynchronous, 0: WAIT is synchronous |
| cfg_wait_en_i | input | 1 | 1: WAIT may stretch the command phase |
| cfg_addr_len_i | input | LW | Address phase cycles |
| cfg_rd_cmd_len_i | input | LW | Minimum command cycles for reads |
| cfg_wr_cmd_len_i | input | LW | Minimum command cycles for writes |
| cfg_rec_len_i | input | LW | Recovery phase cycles |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_we_i | input | 1 | 1: write, 0: read |
| req_addr_i | input | AW | Access address |
| req_wdata_i | input | DW | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read data |
| cfg_err_o | output | 1 | Sticky short-command-length error in asynchronous mode |
| bus_addr_o | output | AW | External address |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_wr_no | output | 1 | Write strobe, active low |
| bus_wdata_o | output | DW | External write data |
| bus_data_i | input | DW | External read data |
| bus_wait_ni | input | 1 | Device WAIT, active low |

## Verification
The bench builds the block with its default values: a 24-bit address, a 32-bit data bus, 4-bit length fields and a two-stage WAIT synchronizer. With these widths, the zero-length clamps and lengths of several cycles can both be reached in short runs. The two-stage chain makes the two-edge asynchronous delay and the forced minimum of 2 directly observable. WAIT patterns of 0 to 5 low samples are driven against command minimums of 1 to 4. This lets both the programmed minimum and the WAIT extension decide the phase length, in each mode and with WAIT disabled.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_CMD  = 2'd2,
    PH_REC  = 2'd3
  } phase_e;
endpackage

// File: rtl/xbus_len_sel.sv
module xbus_len_sel #(
  parameter int unsigned LW           = 4,
  parameter int unsigned ASYNC_STAGES = 2
) (
  input  logic          we_i,
  input  logic          async_i,
  input  logic [LW-1:0] addr_len_i,
  input  logic [LW-1:0] rd_len_i,
  input  logic [LW-1:0] wr_len_i,
  input  logic [LW-1:0] rec_len_i,
  output logic [LW-1:0] addr_eff_o,
  output logic [LW-1:0] cmd_eff_o,
  output logic [LW-1:0] rec_eff_o,
  output logic          short_o
);
  localparam logic [LW-1:0] ONE       = LW'(1);
  localparam logic [LW-1:0] ASYNC_MIN = LW'(ASYNC_STAGES);

  logic [LW-1:0] cmd_raw;
  logic [LW-1:0] cmd_min;

  always_comb begin
    cmd_raw    = we_i ? wr_len_i : rd_len_i;
    cmd_min    = async_i ? ASYNC_MIN : ONE;
    addr_eff_o = (addr_len_i == '0) ? ONE : addr_len_i;
    rec_eff_o  = (rec_len_i == '0) ? ONE : rec_len_i;
    cmd_eff_o  = (cmd_raw < cmd_min) ? cmd_min : cmd_raw;
    short_o    = async_i && (cmd_raw < ASYNC_MIN);
  end
endmodule

// File: rtl/xbus_wait_path.sv
module xbus_wait_path #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_ni,
  input  logic async_i,
  input  logic enable_i,
  output logic hold_o
);
  logic [STAGES-1:0] chain_q;
  logic              eval;

  // sampled every edge; reset to released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], wait_ni};
  end

  assign eval   = async_i ? chain_q[STAGES-1] : chain_q[0];
  assign hold_o = enable_i & ~eval;
endmodule

// File: rtl/xbus_phase_ctl.sv
module xbus_phase_ctl
  import xbus_pkg::*;
#(
  parameter int unsigned LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] addr_len_i,
  input  logic [LW-1:0] cmd_len_i,
  input  logic [LW-1:0] rec_len_i,
  input  logic          hold_i,
  output phase_e        phase_o,
  output logic          cmd_end_o,
  output logic          done_o
);
  phase_e        phase_q;
  logic [LW-1:0] cnt_q;
  logic          done_q;
  logic          cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign cmd_end_o = (phase_q == PH_CMD) && cnt_zero && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_ADDR;
          cnt_q   <= addr_len_i - 1'b1;
        end
        PH_ADDR: if (cnt_zero) begin
          phase_q <= PH_CMD;
          cnt_q   <= cmd_len_i - 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_CMD: if (!cnt_zero) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (!hold_i) begin
          phase_q <= PH_REC;
          cnt_q   <= rec_len_i - 1'b1;
        end
        PH_REC: if (cnt_zero) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;
endmodule

// File: rtl/xbus_access_seq.sv
module xbus_access_seq
  import xbus_pkg::*;
#(
  parameter int unsigned AW           = 24,
  parameter int unsigned DW           = 32,
  parameter int unsigned LW           = 4,
  parameter int unsigned ASYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_async_i,
  input  logic          cfg_wait_en_i,
  input  logic [LW-1:0] cfg_addr_len_i,
  input  logic [LW-1:0] cfg_rd_cmd_len_i,
  input  logic [LW-1:0] cfg_wr_cmd_len_i,
  input  logic [LW-1:0] cfg_rec_len_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          cfg_err_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_cs_no,
  output logic          bus_rd_no,
  output logic          bus_wr_no,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_wait_ni
);
  phase_e        phase;
  logic          idle, start, hold, cmd_end, short_len;
  logic          we_q, async_q, wen_q, err_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [LW-1:0] addr_len_q, rd_len_q, wr_len_q, rec_len_q;
  logic          cur_we, cur_async, cur_wen;
  logic [LW-1:0] cur_addr_len, cur_rd_len, cur_wr_len, cur_rec_len;
  logic [LW-1:0] addr_eff, cmd_eff, rec_eff;

  assign idle  = (phase == PH_IDLE);
  assign start = req_valid_i & idle;

  // live config while idle, latched copy for the rest of the access
  assign cur_we       = idle ? req_we_i         : we_q;
  assign cur_async    = idle ? cfg_async_i      : async_q;
  assign cur_wen      = idle ? cfg_wait_en_i    : wen_q;
  assign cur_addr_len = idle ? cfg_addr_len_i   : addr_len_q;
  assign cur_rd_len   = idle ? cfg_rd_cmd_len_i : rd_len_q;
  assign cur_wr_len   = idle ? cfg_wr_cmd_len_i : wr_len_q;
  assign cur_rec_len  = idle ? cfg_rec_len_i    : rec_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q       <= 1'b0;
      async_q    <= 1'b0;
      wen_q      <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      addr_len_q <= '0;
      rd_len_q   <= '0;
      wr_len_q   <= '0;
      rec_len_q  <= '0;
    end else if (start) begin
      we_q       <= req_we_i;
      async_q    <= cfg_async_i;
      wen_q      <= cfg_wait_en_i;
      addr_q     <= req_addr_i;
      wdata_q    <= req_wdata_i;
      addr_len_q <= cfg_addr_len_i;
      rd_len_q   <= cfg_rd_cmd_len_i;
      wr_len_q   <= cfg_wr_cmd_len_i;
      rec_len_q  <= cfg_rec_len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                err_q <= 1'b0;
    else if (start & short_len) err_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_q <= '0;
    else if (cmd_end && !we_q) rdata_q <= bus_data_i;
  end

  xbus_len_sel #(.LW(LW), .ASYNC_STAGES(ASYNC_STAGES)) u_len (
    .we_i       (cur_we),
    .async_i    (cur_async),
    .addr_len_i (cur_addr_len),
    .rd_len_i   (cur_rd_len),
    .wr_len_i   (cur_wr_len),
    .rec_len_i  (cur_rec_len),
    .addr_eff_o (addr_eff),
    .cmd_eff_o  (cmd_eff),
    .rec_eff_o  (rec_eff),
    .short_o    (short_len)
  );

  xbus_wait_path #(.STAGES(ASYNC_STAGES)) u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wait_ni  (bus_wait_ni),
    .async_i  (cur_async),
    .enable_i (cur_wen),
    .hold_o   (hold)
  );

  xbus_phase_ctl #(.LW(LW)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .addr_len_i (addr_eff),
    .cmd_len_i  (cmd_eff),
    .rec_len_i  (rec_eff),
    .hold_i     (hold),
    .phase_o    (phase),
    .cmd_end_o  (cmd_end),
    .done_o     (done_o)
  );

  assign req_ready_o = idle;
  assign bus_cs_no   = !((phase == PH_ADDR) || (phase == PH_CMD));
  assign bus_rd_no   = !((phase == PH_CMD) && !we_q);
  assign bus_wr_no   = !((phase == PH_CMD) && we_q);
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign rdata_o     = rdata_q;
  assign cfg_err_o   = err_q;
endmodule

// File: rtl/xbus_access_seq_chk.sv
module xbus_access_seq_chk
  import xbus_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          bus_cs_no,
  input logic          bus_rd_no,
  input logic          bus_wr_no,
  input logic          done_o,
  input logic [DW-1:0] rdata_o,
  input logic          cfg_err_o,
  input phase_e        phase,
  input logic          hold
);
  AST_READY_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> bus_cs_no); // R1
  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rd_no || !bus_wr_no) |-> !bus_cs_no); // R2
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bus_rd_no && !bus_wr_no)); // R3
  AST_WAIT_HOLDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_CMD && hold) |=> (phase == PH_CMD)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o); // R6
  AST_RDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $stable(rdata_o)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
endmodule

bind xbus_access_seq xbus_access_seq_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .bus_cs_no   (bus_cs_no),
  .bus_rd_no   (bus_rd_no),
  .bus_wr_no   (bus_wr_no),
  .done_o      (done_o),
  .rdata_o     (rdata_o),
  .cfg_err_o   (cfg_err_o),
  .phase       (phase),
  .hold        (hold)
);

// File: tb/xbus_access_seq_tb_top.sv
module xbus_access_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int LW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_async_i = 1'b0, cfg_wait_en_i = 1'b0;
  logic [LW-1:0] cfg_addr_len_i = '0, cfg_rd_cmd_len_i = '0;
  logic [LW-1:0] cfg_wr_cmd_len_i = '0, cfg_rec_len_i = '0;
  logic          req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0, bus_data_i = '0;
  logic          bus_wait_ni = 1'b1;
  logic          req_ready_o, done_o, cfg_err_o, bus_cs_no, bus_rd_no, bus_wr_no;
  logic [DW-1:0] rdata_o, bus_wdata_o;
  logic [AW-1:0] bus_addr_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xbus_access_seq dut_i (.*);

  typedef struct {
    int            a, c, r;
    logic          we;
    logic [DW-1:0] rd, wd;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0, n_bad = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // driver: computes expectation from requirements and issues one access
  task automatic do_access(input logic we, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                           input logic [DW-1:0] rd, input logic asy, input logic wen,
                           input int a, input int nr, input int nw, input int r, input int w);
    exp_t e;
    int   n;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    n = we ? nw : nr;
    if (n == 0) n = 1;
    if (asy && n < 2) n = 2;
    e.a    = (a == 0) ? 1 : a;
    e.r    = (r == 0) ? 1 : r;
    e.c    = !wen ? n : (asy ? ((w > 0) ? mx(n, w + 2) : n) : mx(n, w + 1));
    e.we   = we;
    e.rd   = rd;
    e.wd   = wd;
    e.addr = addr;
    e.tag  = !wen ? "R3" : (asy ? "R5" : "R4");
    exp_q.push_back(e);
    cfg_async_i = asy; cfg_wait_en_i = wen;
    cfg_addr_len_i = LW'(a); cfg_rd_cmd_len_i = LW'(nr);
    cfg_wr_cmd_len_i = LW'(nw); cfg_rec_len_i = LW'(r);
    req_we_i = we; req_addr_i = addr; req_wdata_i = wd; bus_data_i = rd;
    req_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    // scramble config after acceptance: must not matter
    cfg_rd_cmd_len_i = 4'd9; cfg_wr_cmd_len_i = 4'd9;
    if (w > 0) begin
      repeat (e.a - 1) @(negedge clk_i);
      bus_wait_ni = 1'b0;
      repeat (w) @(negedge clk_i);
      bus_wait_ni = 1'b1;
    end
  endtask

  // monitor: measures phases at the pins and compares with the queue
  initial begin
    int a_cnt = 0, c_cnt = 0, r_cnt = 0;
    logic seen_wr = 1'b0, rdy_bad = 1'b0;
    logic [AW-1:0] seen_addr = '0;
    logic [DW-1:0] seen_wd = '0;
    exp_t e;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        a_cnt = 0; c_cnt = 0; r_cnt = 0; rdy_bad = 1'b0;
      end else if (!bus_cs_no && bus_rd_no && bus_wr_no) begin
        a_cnt++; seen_addr = bus_addr_o;
        if (req_ready_o) rdy_bad = 1'b1;
      end else if (!bus_rd_no || !bus_wr_no) begin
        c_cnt++; seen_wr = !bus_wr_no; seen_wd = bus_wdata_o;
        if (req_ready_o) rdy_bad = 1'b1;
      end else if (done_o) begin
        if (exp_q.size() == 0) begin
          chk("R1 unexpected done", 64'd1, 64'd0);
        end else begin
          e = exp_q.pop_front();
          chk("R1 ready low during access", {63'd0, rdy_bad}, 64'd0);
          chk("R2 address cycles", 64'(a_cnt), 64'(e.a));
          chk("R2 address value", 64'(seen_addr), 64'(e.addr));
          chk({e.tag, " command cycles"}, 64'(c_cnt), 64'(e.c));
          chk("R3 strobe kind", {63'd0, seen_wr}, {63'd0, e.we});
          if (e.we) chk("R3 write data", 64'(seen_wd), 64'(e.wd));
          else      chk("R7 read data", 64'(rdata_o), 64'(e.rd));
          chk("R8 recovery cycles", 64'(r_cnt), 64'(e.r));
        end
        a_cnt = 0; c_cnt = 0; r_cnt = 0; rdy_bad = 1'b0;
      end else if (c_cnt > 0) begin
        r_cnt++;
      end
    end
  end

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_vec++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9 ready in reset", {63'd0, req_ready_o}, 64'd1);
    chk("R9 strobes in reset", {61'd0, bus_cs_no, bus_rd_no, bus_wr_no}, 64'h7);
    chk("R9 done/err in reset", {62'd0, done_o, cfg_err_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 ready after reset", {63'd0, req_ready_o}, 64'd1);

    //        we    addr        wdata         rdata         asy   wen   A  Nr Nw R  W
    do_access(1'b0, 24'h000100, 32'h0,        32'hA5A5_0001, 1'b0, 1'b1, 1, 1, 3, 1, 0);
    do_access(1'b0, 24'h000200, 32'h0,        32'h1234_5678, 1'b0, 1'b1, 2, 1, 4, 2, 2);
    do_access(1'b1, 24'h000300, 32'hDEAD_BEEF, 32'h0,        1'b0, 1'b1, 3, 1, 4, 1, 2);
    do_access(1'b1, 24'h000400, 32'h0BAD_F00D, 32'h0,        1'b0, 1'b1, 1, 3, 2, 3, 5);
    do_access(1'b0, 24'h000500, 32'h0,        32'hCAFE_0005, 1'b0, 1'b0, 2, 3, 1, 1, 4);
    do_access(1'b1, 24'h000600, 32'h5555_AAAA, 32'h0,        1'b0, 1'b1, 0, 2, 0, 0, 0);
    do_access(1'b0, 24'h000700, 32'h0,        32'h7777_0007, 1'b1, 1'b1, 1, 2, 4, 1, 0);
    do_access(1'b0, 24'h000800, 32'h0,        32'h8888_0008, 1'b1, 1'b1, 2, 3, 1, 2, 3);
    do_access(1'b1, 24'h000900, 32'h9999_0009, 32'h0,        1'b1, 1'b1, 1, 4, 2, 1, 1);
    wait (exp_q.size() == 0);
    @(negedge clk_i);
    chk("R6 no error with legal lengths", {63'd0, cfg_err_o}, 64'd0);

    do_access(1'b0, 24'h000A00, 32'h0,        32'h0A0A_000A, 1'b1, 1'b1, 1, 1, 3, 1, 0);
    wait (exp_q.size() == 0);
    @(negedge clk_i);
    chk("R6 error after short async length", {63'd0, cfg_err_o}, 64'd1);

    do_access(1'b1, 24'h000B00, 32'h0B0B_000B, 32'h0,        1'b0, 1'b1, 1, 2, 1, 1, 1);
    wait (exp_q.size() == 0);
    @(negedge clk_i);
    chk("R6 error stays set", {63'd0, cfg_err_o}, 64'd1);

    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 error cleared by reset", {63'd0, cfg_err_o}, 64'd0);
    chk("R9 ready after second reset", {63'd0, req_ready_o}, 64'd1);

    summary();
    $finish;
  end
endmodule